// File: doc/BRIEF.md
# Parallel GPIO Port Controller

This block is the control logic for one small general-purpose I/O port running on the bus clock. Software reaches three byte-wide registers through a plain write strobe, an address and a combinational read path. These registers hold the output latch, the pin directions and the pull-up/pull-down requests. For each pin the block produces an output enable, an output level and a pull request toward the pad, plus a flag saying whether a shared peripheral owns the pin. Pad levels come back through a two-flop synchronizer before software can read them.

The port has six pins. Pins 0 to 3 are bidirectional. Pin 4 is output-only. Pin 5 is input-only. Each pin has a peripheral-enable input that takes the pin away from the port. Pin 4 starts out owned by its debug/mode function and only becomes a port pin once software sets its direction bit. An analog-select input per pin turns that pin's input buffer off.

Top module: `gpio_port`

## Requirements
- R1: For pins 0 to 4, when the direction bit is 1 and the pin is not peripheral-owned, `port_oe` is 1 and `port_out` equals the latch bit. When the direction bit is 0, both are 0.
- R2: A read of address 0 returns the following. For a bidirectional pin, the latch bit when its direction bit is 1 and the synchronized pin level when it is 0. For pin 4, always its latch bit. For pin 5, always its synchronized level.
- R3: A change on `pin_in` shows up in an address-0 read after exactly two rising clock edges. After one edge the read still shows the old level.
- R4: When `periph_en[i]` is 1, `periph_own[i]` is 1 and `port_oe[i]`, `port_out[i]` and `port_pull[i]` are all 0. The register contents are kept unchanged.
- R5: Reset clears the latch, direction and pull registers. Every `port_oe` and `port_pull` bit is then 0, and `periph_own` is 6'b010000.
- R6: Pin 4 is owned by its debug/mode function (`periph_own[4]` = 1, not driven by the port) while direction bit 4 is 0. Setting direction bit 4 to 1 hands it to the port as an output.
- R7: While `analog_sel[i]` is 1, the input path of pin i reads 0. Pin 4 has no input buffer, so its level is never sampled.
- R8: Writes to address 0 update the latch whatever the direction. A preloaded value appears on `port_out` as soon as the direction bit is set.
- R9: Direction bit 5 (the input-only pin) reads 0 and ignores writes, and `port_oe[5]` is always 0. Pull bit 5 is writable.
- R10: Address 0 is data, 1 is direction, 2 is pull enable, and 3 reads 0. Bits 7:6 of every read are 0, and pull bit 4 reads 0.
- R11: `port_pull[i]` is 1 only when pull bit i is 1, direction bit i is 0 and the pin is not peripheral-owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 6 | Raw pad input levels |
| periph_en | input | 6 | Per-pin peripheral takeover |
| analog_sel | input | 6 | Per-pin analog function, input buffer off |
| port_oe | output | 6 | Port output enable toward the pad |
| port_out | output | 6 | Port output level toward the pad |
| port_pull | output | 6 | Pull device request |
| periph_own | output | 6 | Pin owned by a peripheral or the debug function |

## Verification
A wrong direction or latch bit shows up at once on `port_oe`/`port_out` and in an address-0 read, because both are combinational from the registers. A faulty synchronizer shows up as a pin change arriving one edge early or late. The bench probes exactly the first and second edge after a change. Ownership and pull errors are visible in the same cycle as the stimulus, so the sweeps compare every output after each register write.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NUM_BIDIR   = 4,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_BIDIR+1:0] pin_in,
  input  logic [NUM_BIDIR+1:0] periph_en,
  input  logic [NUM_BIDIR+1:0] analog_sel,
  output logic [NUM_BIDIR+1:0] port_oe,
  output logic [NUM_BIDIR+1:0] port_out,
  output logic [NUM_BIDIR+1:0] port_pull,
  output logic [NUM_BIDIR+1:0] periph_own
);
  localparam int NP   = NUM_BIDIR + 2;
  localparam int OPIN = NUM_BIDIR;
  localparam int IPIN = NUM_BIDIR + 1;
  localparam logic [NP-1:0] ONE       = NP'(1);
  localparam logic [NP-1:0] OUT_ONLY  = ONE << OPIN;
  localparam logic [NP-1:0] DIR_MASK  = ~(ONE << IPIN);
  localparam logic [NP-1:0] PULL_MASK = ~OUT_ONLY;
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PULL = AW'(2);

  logic [NP-1:0] lat_q, dir_q, pull_q;
  logic [NP-1:0] sync_q [SYNC_STAGES];
  logic [NP-1:0] in_en, pin_lvl, data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  lat_q  <= bus_wdata[NP-1:0] & DIR_MASK;
        A_DIR:   dir_q  <= bus_wdata[NP-1:0] & DIR_MASK;
        A_PULL:  pull_q <= bus_wdata[NP-1:0] & PULL_MASK;
        default: ;
      endcase
    end
  end

  assign in_en = ~OUT_ONLY & ~analog_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_in & in_en;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_lvl    = sync_q[SYNC_STAGES-1];
  assign periph_own = periph_en | (OUT_ONLY & ~dir_q);
  assign port_oe    = dir_q & ~periph_own;
  assign port_out   = lat_q & port_oe;
  assign port_pull  = pull_q & ~dir_q & ~periph_own;
  assign data_rd    = (dir_q & lat_q) | (~dir_q & ~OUT_ONLY & pin_lvl) | (OUT_ONLY & lat_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA:  bus_rdata[NP-1:0] = data_rd;
      A_DIR:   bus_rdata[NP-1:0] = dir_q;
      A_PULL:  bus_rdata[NP-1:0] = pull_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NP = 6,
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [NP-1:0] pin_in,
  input logic [NP-1:0] periph_en,
  input logic [NP-1:0] analog_sel,
  input logic [NP-1:0] port_oe,
  input logic [NP-1:0] port_pull,
  input logic [NP-1:0] periph_own
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_sync_two_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && bus_addr == AW'(0)) |->
      bus_rdata[NP-1] == $past(pin_in[NP-1] & ~analog_sel[NP-1], 2));

  assert_periph_blocks_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en & (port_oe | port_pull)) == '0);

  assert_periph_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en & ~periph_own) == '0);

  assert_inonly_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !port_oe[NP-1]);

  assert_inonly_dir_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(1)) |-> !bus_rdata[NP-1]);

  assert_unused_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NP] == '0);

  assert_pull_not_on_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_pull & port_oe) == '0);

  assert_outonly_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_oe[NP-2] |-> periph_own[NP-2]);
endmodule

bind gpio_port gpio_port_chk #(.NP(NUM_BIDIR+2), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pin_in(pin_in), .periph_en(periph_en), .analog_sel(analog_sel),
  .port_oe(port_oe), .port_pull(port_pull), .periph_own(periph_own)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = '0, periph_en = '0, analog_sel = '0;
  logic [5:0] port_oe, port_out, port_pull, periph_own;
  logic [5:0] m_lat = '0, m_dir = '0, m_pull = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .periph_en(periph_en), .analog_sel(analog_sel), .port_oe(port_oe),
    .port_out(port_out), .port_pull(port_pull), .periph_own(periph_own)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd0: m_lat  = d[5:0] & 6'h1F;
      2'd1: m_dir  = d[5:0] & 6'h1F;
      2'd2: m_pull = d[5:0] & 6'h2F;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  function automatic logic [5:0] e_own();
    return periph_en | (6'h10 & ~m_dir);
  endfunction
  function automatic logic [5:0] e_oe();
    return m_dir & ~e_own();
  endfunction
  function automatic logic [5:0] e_pull();
    return m_pull & ~m_dir & ~e_own();
  endfunction
  function automatic logic [7:0] e_data();
    return {2'b00, (m_dir & m_lat) | (~m_dir & pin_in & ~analog_sel & 6'h2F) | (m_lat & 6'h10)};
  endfunction

  task automatic chk_pads(string req);
    chk({req, " oe"},   {2'b0, port_oe},    {2'b0, e_oe()});
    chk({req, " out"},  {2'b0, port_out},   {2'b0, m_lat & e_oe()});
    chk({req, " own"},  {2'b0, periph_own}, {2'b0, e_own()});
    chk({req, " pull"}, {2'b0, port_pull},  {2'b0, e_pull()});
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: all requirements act=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    rd(2'd0, v); chk("R5 data after reset", v, 8'h00);
    rd(2'd1, v); chk("R5 dir after reset", v, 8'h00);
    rd(2'd2, v); chk("R5 pull after reset", v, 8'h00);
    chk("R5 oe after reset", {2'b0, port_oe}, 8'h00);
    chk("R5 pull out after reset", {2'b0, port_pull}, 8'h00);
    chk("R5 R6 own after reset", {2'b0, periph_own}, 8'h10);

    // R10 map and unused bits, R9 dir bit 5
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R9 R10 dir readback", v, 8'h1F);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R9 R10 pull readback", v, 8'h2F);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R10 addr3 reads 0", v, 8'h00);
    rd(2'd1, v); chk("R10 addr3 write no effect", v, 8'h1F);
    wr(2'd2, 8'h00);

    // R8 preload
    wr(2'd1, 8'h00); wr(2'd0, 8'h15);
    chk("R8 latch hidden while input", {2'b0, port_out}, 8'h00);
    wr(2'd1, 8'h1F);
    chk("R8 preload appears", {2'b0, port_out}, 8'h15);

    // R1 R6 R9 direction sweep
    wr(2'd0, 8'h1B);
    for (int d = 0; d < 64; d++) begin
      wr(2'd1, 8'(d));
      chk_pads("R1 R6 dir sweep");
      rd(2'd1, v); chk("R9 dir sweep readback", v, {2'b0, m_dir});
    end

    // R2 read source sweep
    wr(2'd0, 8'h0A);
    for (int d = 0; d < 32; d++) begin
      wr(2'd1, 8'(d));
      for (int p = 0; p < 64; p++) begin
        @(negedge clk); pin_in = 6'(p);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk("R2 read source", v, e_data());
      end
    end

    // R3 latency
    wr(2'd1, 8'h00); wr(2'd0, 8'h10);
    @(negedge clk); pin_in = 6'h00;
    repeat (3) @(negedge clk);
    pin_in = 6'h2F;
    @(negedge clk); rd(2'd0, v); chk("R3 old after one edge", v, 8'h10);
    @(negedge clk); rd(2'd0, v); chk("R3 new after two edges", v, 8'h3F);
    pin_in = 6'h00;
    @(negedge clk); rd(2'd0, v); chk("R3 fall old after one edge", v, 8'h3F);
    @(negedge clk); rd(2'd0, v); chk("R3 fall new after two edges", v, 8'h10);

    // R7 analog sweep
    pin_in = 6'h3F;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); analog_sel = 6'(a);
      repeat (2) @(negedge clk);
      rd(2'd0, v); chk("R7 analog gating", v, {2'b0, (~analog_sel & 6'h2F) | 6'h10});
    end
    analog_sel = '0;

    // R4 peripheral sweep
    wr(2'd0, 8'h1F); wr(2'd2, 8'h2F);
    for (int d = 0; d < 2; d++) begin
      wr(2'd1, d ? 8'h1F : 8'h00);
      for (int p = 0; p < 64; p++) begin
        @(negedge clk); periph_en = 6'(p);
        #0.5;
        chk_pads("R4 periph sweep");
      end
    end
    periph_en = '0;
    rd(2'd1, v); chk("R4 dir kept", v, 8'h1F);
    rd(2'd2, v); chk("R4 pull kept", v, 8'h2F);

    // R11 pull sweep
    for (int d = 0; d < 32; d++) begin
      wr(2'd1, 8'(d));
      for (int p = 0; p < 64; p += 3) begin
        wr(2'd2, 8'(p));
        chk("R11 pull", {2'b0, port_pull}, {2'b0, e_pull()});
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule